// File: doc/BRIEF.md
# Control Register Access Virtualizer

This block sits between a guest's control-register accesses and the real register state. It handles two wide control registers (called CR0 and CR4 here) and a narrow task-priority value reached through CR8. For each wide register, the host programs two values. A mask gives host ownership bit by bit. A shadow holds the value the guest is shown for the bits the host owns.

On a guest read, each host-owned bit comes from the shadow and each guest-owned bit comes from the real register. On a guest write, the block checks whether the write would change any host-owned bit away from its shadow value. If it would, the block flags a VM exit and the write is dropped. If it would not, only the guest-owned bits reach the real register.

Task-priority accesses through CR8 use a small shadow priority value. Reading it never exits. A write exits only when the new priority falls strictly below a threshold that the host programs. Exit and read data are combinational from the current state. Register updates commit on the following clock edge.

Top module: `crAccessVirtualizer`

## Requirements
- R1: After reset, the real CR0 and CR4 values, the priority value, both masks, both shadows and the threshold are all zero. A read of any select then returns zero, and a write to CR0, CR4 or CR8 raises no exit.
- R2: Guest select encoding is 0 for CR0, 1 for CR4, 2 for CR8 and 3 for none. A read of CR0 or CR4 returns, bit by bit, the shadow bit where the mask bit is 1 and the real bit where the mask bit is 0. Read data is combinational.
- R3: A guest write to CR0 or CR4 raises gExit in the same cycle exactly when at least one mask-1 bit of the write data differs from the matching shadow bit.
- R4: A CR0 or CR4 write without exit updates the real register at the next clock edge. Mask-0 bits take the write data, and mask-1 bits keep their previous real value.
- R5: A cycle that raises gExit leaves the real CR0 value, the real CR4 value and the priority value unchanged.
- R6: A CR8 read returns the 4-bit priority value in bits 3:0, with all upper bits zero. It never raises gExit.
- R7: A CR8 write compares bits 3:0 of the write data, unsigned, against the threshold. It raises gExit exactly when the value is strictly below the threshold. Otherwise the priority value becomes those 4 bits at the next edge. Upper write-data bits are ignored.
- R8: The configuration select encoding is 0 for the CR0 mask, 1 for the CR0 shadow, 2 for the CR4 mask, 3 for the CR4 shadow and 4 for the threshold (taken from data bits 3:0). Other codes change nothing. A configuration write takes effect from the next cycle, so a guest access in the same cycle sees the old values.
- R9: gExit is low whenever gValid is low or gWrite is low. A write to select 3, or any write with gValid low, raises no exit and changes no register. A read of select 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Host configuration write strobe |
| cfgSel | input | 3 | Configuration target select |
| cfgData | input | DATA_W | Configuration write data |
| gValid | input | 1 | Guest access valid |
| gSel | input | 2 | Guest register select |
| gWrite | input | 1 | Guest access is a write (1) or read (0) |
| gWdata | input | DATA_W | Guest write data |
| gRdata | output | DATA_W | Guest read data as the guest sees it |
| gExit | output | 1 | VM exit required for this access |
| cr0Real | output | DATA_W | Real CR0 value |
| cr4Real | output | DATA_W | Real CR4 value |
| tprValue | output | TPR_W | Shadow task-priority value |

## Verification
The tests use masks with different ownership patterns on CR0 and CR4. Guest writes are tried in three forms: matching the shadow on every owned bit, differing on a single owned bit, and differing only on guest-owned bits. These cases separate a correct exit decision from one that ignores the mask or the shadow.

CR8 writes are tried just below the threshold, exactly at it and just above it, with junk in the upper bits. This separates a strict comparison from a non-strict one and a 4-bit comparison from a wide one.

Configuration writes are issued in the same cycle as guest accesses to show that the guest sees the old values in that cycle. A long pseudo-random run then mixes all selects and codes against the cycle-by-cycle model.

// File: rtl/crv_pkg.sv
package crv_pkg;

  localparam int NUM_CR = 2;

  typedef enum logic [1:0] {
    SEL_CR0  = 2'd0,
    SEL_CR4  = 2'd1,
    SEL_CR8  = 2'd2,
    SEL_NONE = 2'd3
  } guestSel_e;

  localparam logic [2:0] CFG_THRESHOLD = 3'd4;

  typedef struct packed {
    logic [NUM_CR-1:0] crWe;
    logic              tprWe;
    logic [NUM_CR-1:0] maskWe;
    logic [NUM_CR-1:0] shadowWe;
    logic              thrWe;
  } ctlStrobes_t;

  typedef struct packed {
    logic [NUM_CR-1:0] crConflict;
    logic              tprBelow;
  } dpFlags_t;

endpackage

// File: rtl/crv_crBank.sv
module crv_crBank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              maskWe,
  input  logic              shadowWe,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              guestWe,
  input  logic [DATA_W-1:0] guestData,
  output logic [DATA_W-1:0] readVal,
  output logic              conflict,
  output logic [DATA_W-1:0] realVal
);

  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] shadowQ;
  logic [DATA_W-1:0] realQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '0;
      shadowQ <= '0;
      realQ   <= '0;
    end else begin
      if (maskWe)   maskQ   <= cfgData;
      if (shadowWe) shadowQ <= cfgData;
      if (guestWe)  realQ   <= (guestData & ~maskQ) | (realQ & maskQ);
    end
  end

  // Host-owned bits show the shadow, guest-owned bits show the real register.
  assign readVal  = (shadowQ & maskQ) | (realQ & ~maskQ);
  // A host-owned bit that would move away from its shadow forces an exit.
  assign conflict = |((guestData ^ shadowQ) & maskQ);
  assign realVal  = realQ;

endmodule

// File: rtl/crv_datapath.sv
module crv_datapath
  import crv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TPR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [1:0]        gSel,
  input  logic [DATA_W-1:0] gWdata,
  output dpFlags_t          flags,
  output logic [DATA_W-1:0] gRdata,
  output logic [DATA_W-1:0] cr0Real,
  output logic [DATA_W-1:0] cr4Real,
  output logic [TPR_W-1:0]  tprValue
);

  localparam int PAD_W = DATA_W - TPR_W;

  logic [DATA_W-1:0] bankRead [NUM_CR];
  logic [DATA_W-1:0] bankReal [NUM_CR];
  logic [TPR_W-1:0]  tprQ;
  logic [TPR_W-1:0]  thrQ;

  for (genvar i = 0; i < NUM_CR; i++) begin : g_bank
    crv_crBank #(.DATA_W(DATA_W)) u_bank (
      .clk       (clk),
      .rstN      (rstN),
      .maskWe    (strobes.maskWe[i]),
      .shadowWe  (strobes.shadowWe[i]),
      .cfgData   (cfgData),
      .guestWe   (strobes.crWe[i]),
      .guestData (gWdata),
      .readVal   (bankRead[i]),
      .conflict  (flags.crConflict[i]),
      .realVal   (bankReal[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tprQ <= '0;
      thrQ <= '0;
    end else begin
      if (strobes.tprWe) tprQ <= gWdata[TPR_W-1:0];
      if (strobes.thrWe) thrQ <= cfgData[TPR_W-1:0];
    end
  end

  assign flags.tprBelow = gWdata[TPR_W-1:0] < thrQ;

  always_comb begin
    unique case (guestSel_e'(gSel))
      SEL_CR0: gRdata = bankRead[0];
      SEL_CR4: gRdata = bankRead[1];
      SEL_CR8: gRdata = {{PAD_W{1'b0}}, tprQ};
      default: gRdata = '0;
    endcase
  end

  assign cr0Real  = bankReal[0];
  assign cr4Real  = bankReal[1];
  assign tprValue = tprQ;

endmodule

// File: rtl/crv_ctrl.sv
module crv_ctrl
  import crv_pkg::*;
(
  input  logic        cfgWe,
  input  logic [2:0]  cfgSel,
  input  logic        gValid,
  input  logic [1:0]  gSel,
  input  logic        gWrite,
  input  dpFlags_t    flags,
  output ctlStrobes_t strobes,
  output logic        gExit
);

  logic guestWr;
  logic exitReq;

  assign guestWr = gValid && gWrite;

  always_comb begin
    unique case (guestSel_e'(gSel))
      SEL_CR0: exitReq = flags.crConflict[0];
      SEL_CR4: exitReq = flags.crConflict[1];
      SEL_CR8: exitReq = flags.tprBelow;
      default: exitReq = 1'b0;
    endcase
  end

  assign gExit = guestWr && exitReq;

  for (genvar i = 0; i < NUM_CR; i++) begin : g_strobe
    assign strobes.crWe[i]     = guestWr && !exitReq && (gSel == 2'(i));
    assign strobes.maskWe[i]   = cfgWe && (cfgSel == 3'(2 * i));
    assign strobes.shadowWe[i] = cfgWe && (cfgSel == 3'(2 * i + 1));
  end

  assign strobes.tprWe = guestWr && !exitReq && (guestSel_e'(gSel) == SEL_CR8);
  assign strobes.thrWe = cfgWe && (cfgSel == CFG_THRESHOLD);

endmodule

// File: rtl/crAccessVirtualizer.sv
module crAccessVirtualizer
  import crv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TPR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              gValid,
  input  logic [1:0]        gSel,
  input  logic              gWrite,
  input  logic [DATA_W-1:0] gWdata,
  output logic [DATA_W-1:0] gRdata,
  output logic              gExit,
  output logic [DATA_W-1:0] cr0Real,
  output logic [DATA_W-1:0] cr4Real,
  output logic [TPR_W-1:0]  tprValue
);

  ctlStrobes_t strobes;
  dpFlags_t    flags;

  crv_ctrl u_ctrl (
    .cfgWe   (cfgWe),
    .cfgSel  (cfgSel),
    .gValid  (gValid),
    .gSel    (gSel),
    .gWrite  (gWrite),
    .flags   (flags),
    .strobes (strobes),
    .gExit   (gExit)
  );

  crv_datapath #(.DATA_W(DATA_W), .TPR_W(TPR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgData  (cfgData),
    .gSel     (gSel),
    .gWdata   (gWdata),
    .flags    (flags),
    .gRdata   (gRdata),
    .cr0Real  (cr0Real),
    .cr4Real  (cr4Real),
    .tprValue (tprValue)
  );

endmodule

// File: rtl/crv_checker.sv
module crv_checker #(
  parameter int DATA_W = 32,
  parameter int TPR_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              gValid,
  input logic [1:0]        gSel,
  input logic              gWrite,
  input logic [DATA_W-1:0] gWdata,
  input logic [DATA_W-1:0] gRdata,
  input logic              gExit,
  input logic [DATA_W-1:0] cr0Real,
  input logic [DATA_W-1:0] cr4Real,
  input logic [TPR_W-1:0]  tprValue
);

  localparam int PAD_W = DATA_W - TPR_W;

  // R9: exits only on valid writes
  a_r9_exit_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    !(gValid && gWrite) |-> !gExit);

  // R9: the empty select never exits and reads zero
  a_r9_none_select_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (gSel == 2'd3) |-> (!gExit && gRdata == '0));

  // R5: guest-visible state moves only on an accepted guest write
  a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (!rstN)
    !(gValid && gWrite && !gExit) |=>
      ($stable(cr0Real) && $stable(cr4Real) && $stable(tprValue)));

  // R6: priority read is the zero-extended priority value, never exits
  a_r6_tpr_read: assert property (@(posedge clk) disable iff (!rstN)
    (gValid && !gWrite && gSel == 2'd2) |->
      (gRdata == {{PAD_W{1'b0}}, tprValue} && !gExit));

  // R7: accepted priority write loads the low bits of the data
  a_r7_tpr_commit: assert property (@(posedge clk) disable iff (!rstN)
    (gValid && gWrite && gSel == 2'd2 && !gExit) |=>
      (tprValue == $past(gWdata[TPR_W-1:0])));

  // R4: accepted CR0 write leaves CR4 untouched
  a_r4_cr0_isolated: assert property (@(posedge clk) disable iff (!rstN)
    (gValid && gWrite && gSel == 2'd0) |=> $stable(cr4Real));

endmodule

bind crAccessVirtualizer crv_checker #(.DATA_W(DATA_W), .TPR_W(TPR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .gValid   (gValid),
  .gSel     (gSel),
  .gWrite   (gWrite),
  .gWdata   (gWdata),
  .gRdata   (gRdata),
  .gExit    (gExit),
  .cr0Real  (cr0Real),
  .cr4Real  (cr4Real),
  .tprValue (tprValue)
);

// File: tb/crAccessVirtualizer_tb.sv
module crAccessVirtualizer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cfgWe;
  logic [2:0]    cfgSel;
  logic [DW-1:0] cfgData;
  logic          gValid;
  logic [1:0]    gSel;
  logic          gWrite;
  logic [DW-1:0] gWdata;
  logic [DW-1:0] gRdata;
  logic          gExit;
  logic [DW-1:0] cr0Real;
  logic [DW-1:0] cr4Real;
  logic [3:0]    tprValue;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // reference model state
  logic [DW-1:0] mMask [2];
  logic [DW-1:0] mShadow [2];
  logic [DW-1:0] mReal [2];
  int            mTpr;
  int            mThr;

  crAccessVirtualizer #(.DATA_W(DW), .TPR_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .gValid(gValid), .gSel(gSel), .gWrite(gWrite), .gWdata(gWdata),
    .gRdata(gRdata), .gExit(gExit), .cr0Real(cr0Real), .cr4Real(cr4Real),
    .tprValue(tprValue)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 2; i++) begin
      mMask[i] = '0; mShadow[i] = '0; mReal[i] = '0;
    end
    mTpr = 0;
    mThr = 0;
  endtask

  // One cycle: drive, compare combinational outputs and state, then advance model.
  task automatic step(input bit ce, input int cs, input logic [DW-1:0] cd,
                      input bit gv, input int gs, input bit gw,
                      input logic [DW-1:0] gd, input string tag);
    logic [DW-1:0] expRd;
    bit expExit;
    int newTpr;
    @(negedge clk);
    cfgWe = ce; cfgSel = 3'(cs); cfgData = cd;
    gValid = gv; gSel = 2'(gs); gWrite = gw; gWdata = gd;
    #1;
    expRd = '0;
    expExit = 0;
    newTpr = int'(gd[3:0]);
    if (gs < 2) begin
      for (int b = 0; b < DW; b++) begin
        expRd[b] = mMask[gs][b] ? mShadow[gs][b] : mReal[gs][b];
        if (mMask[gs][b] && (gd[b] != mShadow[gs][b])) expExit = 1;
      end
    end else if (gs == 2) begin
      expRd = DW'(mTpr);
      expExit = (newTpr < mThr);
    end
    if (!(gv && gw)) expExit = 0;
    chk(tag, "gRdata", gRdata, expRd);
    chk(tag, "gExit", DW'(gExit), DW'(expExit));
    chk(tag, "cr0Real", cr0Real, mReal[0]);
    chk(tag, "cr4Real", cr4Real, mReal[1]);
    chk(tag, "tprValue", DW'(tprValue), DW'(mTpr));
    @(posedge clk);
    if (gv && gw && !expExit) begin
      if (gs < 2) begin
        for (int b = 0; b < DW; b++)
          if (!mMask[gs][b]) mReal[gs][b] = gd[b];
      end else if (gs == 2) begin
        mTpr = newTpr;
      end
    end
    if (ce) begin
      case (cs)
        0: mMask[0] = cd;
        1: mShadow[0] = cd;
        2: mMask[1] = cd;
        3: mShadow[1] = cd;
        4: mThr = int'(cd[3:0]);
        default: ;
      endcase
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    rstN = 0; cfgWe = 0; cfgSel = 0; cfgData = 0;
    gValid = 0; gSel = 0; gWrite = 0; gWdata = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R1: reset state, reads and writes
    step(0, 0, 0, 1, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 1, 0, 0, "R1");
    step(0, 0, 0, 1, 2, 0, 0, "R1");
    step(0, 0, 0, 1, 2, 1, 32'h0, "R1");

    // R8: config in same cycle as guest read sees old values
    step(1, 0, 32'h0000_00F0, 1, 0, 0, 0, "R8");
    step(1, 1, 32'h0000_0050, 1, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 0, 0, 0, "R8");
    step(1, 6, 32'hFFFF_FFFF, 1, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 0, 0, 0, "R8");

    // R4 / R2: owned bits match shadow, guest bits written
    step(0, 0, 0, 1, 0, 1, 32'hFFFF_FF5A, "R4");
    step(0, 0, 0, 1, 0, 0, 0, "R2");
    // R3 / R5: one owned bit differs
    step(0, 0, 0, 1, 0, 1, 32'h0000_0070, "R3");
    step(0, 0, 0, 1, 0, 0, 0, "R5");
    // R3: only guest bits differ -> no exit
    step(0, 0, 0, 1, 0, 1, 32'h1234_0051, "R3");
    step(0, 0, 0, 1, 0, 0, 0, "R2");

    // CR4 with a scattered mask
    step(1, 2, 32'h8000_0101, 0, 0, 0, 0, "R8");
    step(1, 3, 32'h8000_0001, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 1, 1, 32'hFFFF_FEFF, "R4");
    step(0, 0, 0, 1, 1, 0, 0, "R2");
    step(0, 0, 0, 1, 1, 1, 32'h8000_0000, "R3");
    step(0, 0, 0, 1, 1, 0, 0, "R5");

    // R7: threshold boundaries, upper bits ignored
    step(1, 4, 32'hFFFF_FFF8, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 2, 1, 32'h0000_0007, "R7");
    step(0, 0, 0, 1, 2, 0, 0, "R6");
    step(0, 0, 0, 1, 2, 1, 32'hFFFF_FFF8, "R7");
    step(0, 0, 0, 1, 2, 0, 0, "R6");
    step(0, 0, 0, 1, 2, 1, 32'h0000_0019, "R7");
    step(0, 0, 0, 1, 2, 1, 32'hABCD_EF03, "R7");
    step(1, 4, 32'h0000_0002, 1, 2, 1, 32'h0000_0003, "R7");
    step(0, 0, 0, 1, 2, 1, 32'hABCD_EF03, "R7");
    step(0, 0, 0, 1, 2, 0, 0, "R6");

    // R9: empty select and invalid writes
    step(0, 0, 0, 1, 3, 1, 32'hFFFF_FFFF, "R9");
    step(0, 0, 0, 0, 0, 1, 32'h0000_0000, "R9");
    step(0, 0, 0, 0, 2, 1, 32'h0000_0000, "R9");
    step(0, 0, 0, 1, 3, 0, 0, "R9");

    // mixed run
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom;
      step(r[0], $urandom_range(0, 5), $urandom, r[1] | r[2], r[4:3], r[5],
           (r[7:6] == 0) ? mShadow[r[3]] : $urandom, "R3");
    end

    finish();
  end

endmodule